// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A single-port synchronous memory with a fixed two-stage pipeline. A command is captured on one rising clock edge: the address, the read/write select, a load strobe and three chip selects. The data transfer for that command happens exactly two edges later. Reads and writes take the same latency, so the data slots of consecutive commands never collide. Any mix of reads and writes can therefore be issued on every cycle with no idle cycle between them.

The bidirectional data bus is modelled as a data input, a data output and an output-drive flag. Read data is registered at the first edge after issue and driven in the cycle that ends at the second edge, where the host samples it. Write data is sampled from the data input at the second edge and committed to the array there. A read that follows a write to the same address by one cycle takes the write data straight from the bus.

An active-low clock enable freezes the whole block. An asynchronous active-low output enable can silence the outputs at any time. A synchronous reset clears the pipeline's valid state and leaves the array contents alone.

Top module: `pipe_sram`

## Requirements
- R1: A read issued at edge k drives `dOutEn` high in the cycle between edges k+1 and k+2, with `dOut` holding the data stored at its address, provided `outEnN` is low.
- R2: A write issued at edge k stores the value on `dIn` at edge k+2 into the addressed word.
- R3: Reads and writes issued on consecutive enabled cycles, in any order, all complete with no idle cycle between commands.
- R4: While `clkEnN` is high, every input is ignored and all state holds: no command is issued, no write commits, and `dOut`/`dOutEn` keep their values.
- R5: A command is issued only when `loadN` is 0, `sel1N` is 0, `sel2` is 1 and `sel3N` is 0. Otherwise nothing is written and the matching data slot is not driven.
- R6: Deselecting the block does not cancel commands already issued, and their reads and writes still complete.
- R7: `dOutEn` is low in every data slot that belongs to a write or to a cycle with no command.
- R8: `outEnN` high forces `dOutEn` low at once, without waiting for a clock edge, whatever the pipeline holds.
- R9: A read issued one cycle after a write to the same address returns the new write data. A read issued two cycles after such a write also returns the new data.
- R10: A synchronous reset (`rst` high at an edge) empties the pipeline, so `dOutEn` is low after it. The array keeps its contents.
- R11: `rdWr` selects the operation: 1 is a read and 0 is a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears the pipeline only |
| clkEnN | input | 1 | Clock enable, active low; high freezes the block |
| loadN | input | 1 | Load strobe, active low; a command may issue only when low |
| sel1N | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3N | input | 1 | Chip select, active low |
| rdWr | input | 1 | Operation select: 1 read, 0 write |
| addr | input | AW (4) | Word address |
| outEnN | input | 1 | Asynchronous output enable, active low |
| dIn | input | DW (16) | Write data, sampled two edges after issue |
| dOut | output | DW (16) | Read data |
| dOutEn | output | 1 | High when the block drives the data bus |

## Verification
The array is first filled with a burst of back-to-back writes and read back with a burst of back-to-back reads, which separates wrong latency from wrong addressing. Alternating read/write streams check for slot collisions. Same-address write-then-read pairs at distances one and two tell a forwarding fault apart from a plain array fault. Each chip select is dropped in turn, and the load strobe is raised, to show that each one alone blocks a command. Deselecting right after live commands shows that in-flight transfers finish. Freezes are placed with a read and with a write in the last stage, and junk sits on the data bus during them, to show that nothing moves. The output enable is toggled mid-cycle, away from any edge.

// File: rtl/pipe_sram_pkg.sv
`timescale 1ns/1ps
package pipe_sram_pkg;

  // Strobes from the pipeline control to the storage datapath
  typedef struct packed {
    logic commitWr;   // write dIn into the array at this edge
    logic captureRd;  // load the read register at this edge
    logic forward;    // take the read word from dIn instead of the array
    logic driveRd;    // a read occupies the final stage
  } strobe_t;

  // One pipeline stage's command state
  typedef struct packed {
    logic valid;
    logic isWrite;
  } stage_t;

endpackage

// File: rtl/pipe_sram_ctrl.sv
`timescale 1ns/1ps
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clkEnN,
  input  logic          loadN,
  input  logic          sel1N,
  input  logic          sel2,
  input  logic          sel3N,
  input  logic          rdWr,
  input  logic [AW-1:0] addr,
  output strobe_t       stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr
);

  localparam int NSTAGE = 2;

  stage_t        stage [NSTAGE];
  logic [AW-1:0] stAddr [NSTAGE];

  logic issue;
  logic advance;

  assign advance = ~clkEnN;
  assign issue   = ~loadN & ~sel1N & sel2 & ~sel3N;

  // Stage 0 takes a fresh command; later stages shift forward
  genvar g;
  generate
    for (g = 0; g < NSTAGE; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage[g].valid <= 1'b0;
        end else if (advance) begin
          if (g == 0) begin
            stage[g].valid   <= issue;
            stage[g].isWrite <= ~rdWr;
            stAddr[g]        <= addr;
          end else begin
            stage[g]  <= stage[g-1];
            stAddr[g] <= stAddr[g-1];
          end
        end
      end
    end
  endgenerate

  // Front stage feeds the read register; back stage owns the bus slot
  always_comb begin
    stb.commitWr  = advance & ~rst & stage[1].valid & stage[1].isWrite;
    stb.captureRd = advance & stage[0].valid & ~stage[0].isWrite;
    stb.forward   = stage[1].valid & stage[1].isWrite & (stAddr[1] == stAddr[0]);
    stb.driveRd   = stage[1].valid & ~stage[1].isWrite;
  end

  assign wrAddr = stAddr[1];
  assign rdAddr = stAddr[0];

endmodule

// File: rtl/pipe_sram_dp.sv
`timescale 1ns/1ps
module pipe_sram_dp
  import pipe_sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  strobe_t       stb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] dIn,
  output logic [DW-1:0] dOut
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdReg;
  logic [DW-1:0] rdWord;

  // A write committing at this very edge wins over the stale array word
  assign rdWord = stb.forward ? dIn : mem[rdAddr];

  always_ff @(posedge clk) begin
    if (stb.commitWr) mem[wrAddr] <= dIn;
  end

  always_ff @(posedge clk) begin
    if (stb.captureRd) rdReg <= rdWord;
  end

  assign dOut = rdReg;

endmodule

// File: rtl/pipe_sram.sv
`timescale 1ns/1ps
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clkEnN,
  input  logic          loadN,
  input  logic          sel1N,
  input  logic          sel2,
  input  logic          sel3N,
  input  logic          rdWr,
  input  logic [AW-1:0] addr,
  input  logic          outEnN,
  input  logic [DW-1:0] dIn,
  output logic [DW-1:0] dOut,
  output logic          dOutEn
);

  strobe_t       stb;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  pipe_sram_ctrl #(.AW(AW)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .clkEnN (clkEnN),
    .loadN  (loadN),
    .sel1N  (sel1N),
    .sel2   (sel2),
    .sel3N  (sel3N),
    .rdWr   (rdWr),
    .addr   (addr),
    .stb    (stb),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr)
  );

  pipe_sram_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk    (clk),
    .stb    (stb),
    .wrAddr (wrAddr),
    .rdAddr (rdAddr),
    .dIn    (dIn),
    .dOut   (dOut)
  );

  // Output enable is the only path that bypasses the clock
  assign dOutEn = stb.driveRd & ~outEnN;

endmodule

// File: rtl/pipe_sram_chk.sv
`timescale 1ns/1ps
module pipe_sram_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          clkEnN,
  input logic          loadN,
  input logic          sel1N,
  input logic          sel2,
  input logic          sel3N,
  input logic          rdWr,
  input logic          outEnN,
  input logic [DW-1:0] dOut,
  input logic          dOutEn
);

  // Port-level shadow of which slots carry a read
  logic p1v, p1r, p2v, p2r;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1v <= 1'b0;
      p2v <= 1'b0;
    end else if (!clkEnN) begin
      p1v <= !loadN && !sel1N && sel2 && !sel3N;
      p1r <= rdWr;
      p2v <= p1v;
      p2r <= p1r;
    end
  end

  // R1
  read_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (p2v && p2r && !outEnN) |-> dOutEn);

  // R7
  idle_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    !(p2v && p2r) |-> !dOutEn);

  // R8
  oe_hiz_chk: assert property (@(posedge clk) disable iff (rst)
    outEnN |-> !dOutEn);

  // R4
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(clkEnN) && !$past(rst)) |-> $stable(dOut));

endmodule

bind pipe_sram pipe_sram_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .clkEnN (clkEnN),
  .loadN  (loadN),
  .sel1N  (sel1N),
  .sel2   (sel2),
  .sel3N  (sel3N),
  .rdWr   (rdWr),
  .outEnN (outEnN),
  .dOut   (dOut),
  .dOutEn (dOutEn)
);

// File: tb/pipe_sram_bench.sv
`timescale 1ns/1ps
module pipe_sram_bench;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clkEnN = 1'b0;
  logic          loadN = 1'b1;
  logic          sel1N = 1'b0;
  logic          sel2 = 1'b1;
  logic          sel3N = 1'b0;
  logic          rdWr = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          outEnN = 1'b0;
  logic [DW-1:0] dIn = '0;
  logic [DW-1:0] dOut;
  logic          dOutEn;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pipe_sram #(.AW(AW), .DW(DW)) u_pipe_sram (
    .clk(clk), .rst(rst), .clkEnN(clkEnN), .loadN(loadN),
    .sel1N(sel1N), .sel2(sel2), .sel3N(sel3N), .rdWr(rdWr),
    .addr(addr), .outEnN(outEnN), .dIn(dIn), .dOut(dOut), .dOutEn(dOutEn)
  );

  // Bench-side model of the command pipeline and the array
  logic          m1v = 0, m1w = 0, m2v = 0, m2w = 0;
  logic [AW-1:0] m1a = '0, m2a = '0;
  logic [DW-1:0] m1d = '0, m2d = '0;
  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] expRd = '0;

  task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkOut(input string tag);
    logic expEn;
    expEn = m2v && !m2w && !outEnN;
    check(dOutEn === expEn, {tag, " dOutEn"}, {15'b0, dOutEn}, {15'b0, expEn});
    if (expEn) check(dOut === expRd, {tag, " dOut"}, dOut, expRd);
  endtask

  task automatic tick(input logic ce, input logic ld, input logic s1N, input logic s2,
                      input logic s3N, input logic rd, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input string tag);
    @(negedge clk);
    clkEnN = !ce; loadN = ld; sel1N = s1N; sel2 = s2; sel3N = s3N;
    rdWr = rd; addr = a;
    dIn = (ce && m2v && m2w) ? m2d : 16'hDEAD;
    @(posedge clk);
    if (rst) begin
      m1v = 0; m2v = 0;
    end else if (ce) begin
      if (m2v && m2w) shadow[m2a] = dIn;
      if (m1v && !m1w) expRd = shadow[m1a];
      m2v = m1v; m2w = m1w; m2a = m1a; m2d = m1d;
      m1v = !ld && !s1N && s2 && !s3N;
      m1w = !rd; m1a = a; m1d = wd;
    end
    #1;
    checkOut(tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
    tick(1, 0, 0, 1, 0, 0, a, d, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    tick(1, 0, 0, 1, 0, 1, a, '0, tag);
  endtask

  task automatic nop(input string tag);
    tick(1, 1, 0, 1, 0, 1, '0, '0, tag);
  endtask

  task automatic testReset();
    rst = 1;
    nop("R10 reset"); nop("R10 reset");
    rst = 0;
    check(dOutEn === 1'b0, "R10 idle after reset", {15'b0, dOutEn}, '0);
  endtask

  task automatic testFill();
    for (int i = 0; i < DEPTH; i++) wr(i[AW-1:0], 16'h1000 + 16'(i * 7), "R2 fill");
    nop("R2 flush"); nop("R2 flush");
  endtask

  task automatic testReadBack();
    for (int i = DEPTH - 1; i >= 0; i--) rd(i[AW-1:0], "R1 readback");
    nop("R1 flush"); nop("R1 flush");
  endtask

  task automatic testMixed();
    for (int i = 0; i < 6; i++) begin
      rd(i[AW-1:0], "R3 R11 mixed rd");
      wr(4'(i + 8), 16'h2200 + 16'(i), "R3 R11 mixed wr");
    end
    for (int i = 8; i < 14; i++) rd(i[AW-1:0], "R3 mixed verify");
    nop("R3 flush"); nop("R3 flush");
  endtask

  task automatic testForward();
    wr(4'd3, 16'h3A3A, "R9 fwd wr");
    rd(4'd3, "R9 fwd one");
    wr(4'd4, 16'h4B4B, "R9 fwd wr");
    nop("R9 gap");
    rd(4'd4, "R9 fwd two");
    wr(4'd5, 16'h5C5C, "R9 fwd wr");
    wr(4'd5, 16'h5D5D, "R9 fwd wr2");
    rd(4'd5, "R9 fwd newest");
    nop("R9 flush"); nop("R9 flush");
  endtask

  task automatic testSelect();
    tick(1, 1, 0, 1, 0, 0, 4'd6, 16'hBAD1, "R5 load high");
    tick(1, 0, 1, 1, 0, 0, 4'd6, 16'hBAD2, "R5 sel1N high");
    tick(1, 0, 0, 0, 0, 0, 4'd6, 16'hBAD3, "R5 sel2 low");
    tick(1, 0, 0, 1, 1, 0, 4'd6, 16'hBAD4, "R5 sel3N high");
    tick(1, 0, 1, 1, 0, 1, 4'd6, '0, "R5 deselected read");
    nop("R5 gap"); nop("R5 gap");
    rd(4'd6, "R5 word unchanged");
    nop("R5 flush"); nop("R5 flush");
  endtask

  task automatic testInflight();
    rd(4'd7, "R6 rd before deselect");
    wr(4'd7, 16'h7E7E, "R6 wr before deselect");
    tick(1, 0, 0, 0, 0, 1, '0, '0, "R6 deselect");
    tick(1, 0, 1, 1, 0, 1, '0, '0, "R6 deselect");
    rd(4'd7, "R6 write landed");
    nop("R6 flush"); nop("R6 flush");
  endtask

  task automatic testHiZ();
    wr(4'd9, 16'h9999, "R7 wr");
    nop("R7 nop");
    check(dOutEn === 1'b0, "R7 write slot", {15'b0, dOutEn}, '0);
    nop("R7 nop");
    check(dOutEn === 1'b0, "R7 empty slot", {15'b0, dOutEn}, '0);
  endtask

  task automatic testFreeze();
    rd(4'd2, "R4 rd");
    nop("R4 drive");
    tick(0, 0, 0, 1, 0, 0, 4'd0, 16'hBEEF, "R4 frozen");
    tick(0, 0, 0, 1, 0, 0, 4'd0, 16'hBEEF, "R4 frozen");
    nop("R4 resume");
    wr(4'd10, 16'hAAAA, "R4 wr");
    nop("R4 wr stage2");
    tick(0, 0, 0, 1, 0, 0, 4'd1, 16'hBEEF, "R4 frozen wr");
    tick(0, 0, 0, 1, 0, 0, 4'd1, 16'hBEEF, "R4 frozen wr");
    nop("R4 resume wr");
    rd(4'd10, "R4 wr kept");
    rd(4'd0, "R4 ignored wr");
    rd(4'd1, "R4 ignored wr");
    nop("R4 flush"); nop("R4 flush");
  endtask

  task automatic testOutEnable();
    rd(4'd11, "R8 rd");
    nop("R8 drive");
    outEnN = 1; #0.5;
    check(dOutEn === 1'b0, "R8 async off", {15'b0, dOutEn}, '0);
    outEnN = 0; #0.5;
    check(dOutEn === 1'b1, "R8 async on", {15'b0, dOutEn}, 16'h1);
    check(dOut === shadow[11], "R8 data kept", dOut, shadow[11]);
    nop("R8 flush");
  endtask

  task automatic testResetKeeps();
    rd(4'd12, "R10 rd before reset");
    rst = 1;
    nop("R10 reset in flight");
    rst = 0;
    nop("R10 no stray drive");
    rd(4'd12, "R10 array kept");
    nop("R10 flush"); nop("R10 flush");
  endtask

  initial begin
    testReset();
    testFill();
    testReadBack();
    testMixed();
    testForward();
    testSelect();
    testInflight();
    testHiZ();
    testFreeze();
    testOutEnable();
    testResetKeeps();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule